// File: doc/BRIEF.md
# Frame Header Decoder and Buffer Fit Check

This block runs once at the start of every display frame. It is given the first 16-bit word of the frame's palette header, together with the current palette/load mode, the TFT flag, the panel width and height in pixels, the subpanel control word and the byte size of the active frame buffer. From these it works out the frame's pixel depth, where the pixel data starts after the header, the byte stride of one line, the first line to draw and how many lines to draw.

It also checks whether the frame fits in the buffer. When it does not, it raises a sync error, and the controller must then disable itself. A header whose depth code is zero is flagged as skipped, and a skipped header never raises an error.

All results are captured in registers on the header-valid strobe. They appear one cycle later together with a one-cycle done pulse, and they hold until the next strobe. Palette storage and pixel expansion are handled elsewhere.

Top module: `frame_hdr_decode`

## Requirements
- R1: `done` is high in exactly the cycle after each cycle in which `hdr_valid` is high, and in no other cycle. All other outputs take their new values in that same cycle.
- R2: The depth code is `hdr_word[14:12]`. Code 1 gives `bpp`=2, code 2 gives 4, code 3 gives 8, and codes 4 to 7 give 16. No other bit of `hdr_word` affects any output.
- R3: Depth code 0 gives `skip`=1, `bpp`=0, `stride`=0 and `sync_err`=0, whatever the buffer size. Every non-zero code gives `skip`=0.
- R4: When `load_mode` is 2, `data_offset` is 0. For any other mode, `data_offset` is 512 for codes 3 to 7 and 32 for codes 0 to 2.
- R5: `direct16` is 1 only when `bpp` is 16 and `tft_mode` is 1. Otherwise it is 0, which selects 12-bit colour.
- R6: `stride` equals floor(`panel_width` * `bpp` / 8).
- R7: For a non-zero code, `sync_err` is 1 exactly when `data_offset` + floor(`panel_width` * `panel_height` * `bpp` / 8) > `buf_bytes` + 2. The panel height is used here even when the subpanel replaces the line count. A frame needing exactly `buf_bytes`+2 bytes does not raise an error.
- R8: When `subpanel[31]` is 0, `first_line` is 0 and `line_count` is `panel_height`. When `subpanel[31]` and `subpanel[29]` are both 1, `first_line` is `subpanel[25:16]` and `line_count` is `panel_height`. When `subpanel[31]` is 1 and `subpanel[29]` is 0, `first_line` is 0 and `line_count` is `subpanel[25:16]`.
- R9: After reset, every output is 0. Outputs keep their values in every cycle that does not follow a strobe, whatever the inputs do.
- R10: The fit check uses arithmetic wide enough for a 1024x1024 panel at 16 bits per pixel to give the exact result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_valid | input | 1 | Header word strobe, one per frame |
| hdr_word | input | 16 | First palette header word |
| load_mode | input | 2 | Palette/load mode; 2 means no palette header |
| tft_mode | input | 1 | TFT panel flag |
| panel_width | input | DIM_W (11) | Panel width in pixels |
| panel_height | input | DIM_W (11) | Panel height in lines |
| subpanel | input | 32 | Subpanel control word |
| buf_bytes | input | SIZE_W (32) | Byte size of the active frame buffer |
| done | output | 1 | One-cycle pulse when results are updated |
| skip | output | 1 | Depth code 0; the frame is not drawn |
| bpp | output | 5 | Bits per pixel (0, 2, 4, 8 or 16) |
| direct16 | output | 1 | 16-bit direct colour selected |
| data_offset | output | 10 | Byte offset of the pixel data |
| stride | output | DIM_W+1 (12) | Line stride in bytes |
| first_line | output | LINE_W (10) | First line to draw |
| line_count | output | DIM_W (11) | Number of lines to draw |
| sync_err | output | 1 | Frame does not fit in the buffer |

## Verification
On every cycle the assertions check the following:
- the done pulse follows the strobe by one cycle;
- the outputs hold between strobes;
- a skipped header carries no error and a zero depth;
- a no-palette mode gives a zero offset;
- the stride tracks the width seen at the strobe.

Only the bench's scenarios can show the rest:
- the full depth mapping, including codes 5 to 7;
- the 512/32 offset split;
- the exact edge of the fit check at two bytes of slack, and its behaviour at the 1024x1024 limit;
- the three subpanel cases.

// File: rtl/fhd_pkg.sv
package fhd_pkg;
  localparam logic [1:0] MODE_NO_HDR = 2'd2;
  localparam int unsigned BIG_HDR_BYTES   = 512;
  localparam int unsigned SMALL_HDR_BYTES = 32;

  function automatic logic [4:0] code_to_bpp(input logic [2:0] code);
    logic [4:0] r;
    unique case (code)
      3'd0:    r = 5'd0;
      3'd1:    r = 5'd2;
      3'd2:    r = 5'd4;
      3'd3:    r = 5'd8;
      default: r = 5'd16;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/fhd_depth_decode.sv
module fhd_depth_decode
  import fhd_pkg::*;
(
  input  logic [2:0] code,
  input  logic [1:0] mode,
  input  logic       tft,
  output logic [4:0] bits_pp,
  output logic       is_skip,
  output logic       is_direct,
  output logic [9:0] hdr_offset
);
  always_comb begin
    bits_pp   = code_to_bpp(code);
    is_skip   = (code == 3'd0);
    is_direct = code[2] & tft;
    if (mode == MODE_NO_HDR)
      hdr_offset = 10'd0;
    else if (code >= 3'd3)
      hdr_offset = 10'(BIG_HDR_BYTES);
    else
      hdr_offset = 10'(SMALL_HDR_BYTES);
  end
endmodule

// File: rtl/fhd_geometry.sv
module fhd_geometry #(
  parameter int DIM_W  = 11,
  parameter int LINE_W = 10,
  parameter int SIZE_W = 32
) (
  input  logic [4:0]        bits_pp,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  input  logic [9:0]        hdr_offset,
  input  logic [SIZE_W-1:0] size_bytes,
  input  logic              sp_enable,
  input  logic              sp_is_start,
  input  logic [LINE_W-1:0] sp_lines,
  output logic [DIM_W:0]    line_bytes,
  output logic              too_big,
  output logic [LINE_W-1:0] start_line,
  output logic [DIM_W-1:0]  num_lines
);
  localparam int PROD_W = 2 * DIM_W + 5;
  localparam int ACC_W  = (PROD_W > SIZE_W ? PROD_W : SIZE_W) + 2;

  logic [DIM_W+4:0]  row_bits;
  logic [PROD_W-1:0] frame_bits;
  logic [ACC_W-1:0]  need_bytes;
  logic [ACC_W-1:0]  limit_bytes;

  always_comb begin
    row_bits    = (DIM_W+5)'(width) * (DIM_W+5)'(bits_pp);
    line_bytes  = row_bits[DIM_W+3:3];
    frame_bits  = PROD_W'(row_bits) * PROD_W'(height);
    need_bytes  = ACC_W'(frame_bits >> 3) + ACC_W'(hdr_offset);
    limit_bytes = ACC_W'(size_bytes) + ACC_W'(2);
    too_big     = need_bytes > limit_bytes;

    start_line = '0;
    num_lines  = height;
    if (sp_enable) begin
      if (sp_is_start)
        start_line = sp_lines;
      else
        num_lines = DIM_W'(sp_lines);
    end
  end
endmodule

// File: rtl/frame_hdr_decode.sv
module frame_hdr_decode #(
  parameter int DIM_W  = 11,
  parameter int LINE_W = 10,
  parameter int SIZE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_valid,
  input  logic [15:0]       hdr_word,
  input  logic [1:0]        load_mode,
  input  logic              tft_mode,
  input  logic [DIM_W-1:0]  panel_width,
  input  logic [DIM_W-1:0]  panel_height,
  input  logic [31:0]       subpanel,
  input  logic [SIZE_W-1:0] buf_bytes,
  output logic              done,
  output logic              skip,
  output logic [4:0]        bpp,
  output logic              direct16,
  output logic [9:0]        data_offset,
  output logic [DIM_W:0]    stride,
  output logic [LINE_W-1:0] first_line,
  output logic [DIM_W-1:0]  line_count,
  output logic              sync_err
);
  logic [4:0]        dec_bpp;
  logic              dec_skip, dec_direct;
  logic [9:0]        dec_offset;
  logic [DIM_W:0]    geo_stride;
  logic              geo_too_big;
  logic [LINE_W-1:0] geo_first;
  logic [DIM_W-1:0]  geo_count;

  logic              skip_d, direct_d, err_d;
  logic [4:0]        bpp_d;
  logic [DIM_W:0]    stride_d;

  logic unused_bits;
  assign unused_bits = ^{hdr_word[15], hdr_word[11:0], subpanel[30], subpanel[28:26],
                         subpanel[15:0]};

  fhd_depth_decode u_depth (
    .code       (hdr_word[14:12]),
    .mode       (load_mode),
    .tft        (tft_mode),
    .bits_pp    (dec_bpp),
    .is_skip    (dec_skip),
    .is_direct  (dec_direct),
    .hdr_offset (dec_offset)
  );

  fhd_geometry #(.DIM_W(DIM_W), .LINE_W(LINE_W), .SIZE_W(SIZE_W)) u_geom (
    .bits_pp     (dec_bpp),
    .width       (panel_width),
    .height      (panel_height),
    .hdr_offset  (dec_offset),
    .size_bytes  (buf_bytes),
    .sp_enable   (subpanel[31]),
    .sp_is_start (subpanel[29]),
    .sp_lines    (subpanel[16 +: LINE_W]),
    .line_bytes  (geo_stride),
    .too_big     (geo_too_big),
    .start_line  (geo_first),
    .num_lines   (geo_count)
  );

  always_comb begin
    skip_d   = dec_skip;
    bpp_d    = dec_bpp;
    direct_d = dec_direct;
    stride_d = geo_stride;
    err_d    = geo_too_big & ~dec_skip;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done <= 1'b0;
    else        done <= hdr_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip        <= 1'b0;
      bpp         <= '0;
      direct16    <= 1'b0;
      data_offset <= '0;
      stride      <= '0;
      first_line  <= '0;
      line_count  <= '0;
      sync_err    <= 1'b0;
    end else if (hdr_valid) begin
      skip        <= skip_d;
      bpp         <= bpp_d;
      direct16    <= direct_d;
      data_offset <= dec_offset;
      stride      <= stride_d;
      first_line  <= geo_first;
      line_count  <= geo_count;
      sync_err    <= err_d;
    end
  end
endmodule

// File: rtl/fhd_checker.sv
module fhd_checker #(
  parameter int DIM_W  = 11,
  parameter int LINE_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_valid,
  input logic [1:0]        load_mode,
  input logic [DIM_W-1:0]  panel_width,
  input logic              done,
  input logic              skip,
  input logic [4:0]        bpp,
  input logic              direct16,
  input logic [9:0]        data_offset,
  input logic [DIM_W:0]    stride,
  input logic [LINE_W-1:0] first_line,
  input logic [DIM_W-1:0]  line_count,
  input logic              sync_err
);
  assert_done_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |=> done);
  assert_no_stray_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> !done);
  assert_skip_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    skip |-> (!sync_err && bpp == 5'd0 && stride == '0));
  assert_depth_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !skip) |-> ($countones(bpp) == 1 && bpp >= 5'd2));
  assert_no_hdr_offset_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && load_mode == 2'd2) |=> data_offset == 10'd0);
  assert_direct_only16_R5: assert property (@(posedge clk) disable iff (!rst_n)
    direct16 |-> bpp == 5'd16);
  assert_stride_width_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> 32'(stride) == ((32'($past(panel_width)) * 32'(bpp)) >> 3));
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !hdr_valid |=> ($stable(bpp) && $stable(skip) && $stable(direct16) &&
                    $stable(data_offset) && $stable(stride) && $stable(first_line) &&
                    $stable(line_count) && $stable(sync_err)));
endmodule

bind frame_hdr_decode fhd_checker #(.DIM_W(DIM_W), .LINE_W(LINE_W)) u_fhd_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hdr_valid   (hdr_valid),
  .load_mode   (load_mode),
  .panel_width (panel_width),
  .done        (done),
  .skip        (skip),
  .bpp         (bpp),
  .direct16    (direct16),
  .data_offset (data_offset),
  .stride      (stride),
  .first_line  (first_line),
  .line_count  (line_count),
  .sync_err    (sync_err)
);

// File: tb/tb_frame_hdr_decode.sv
module tb_frame_hdr_decode;
  localparam int DIM_W = 11, LINE_W = 10, SIZE_W = 32;

  typedef struct packed {
    logic [2:0]  code;
    logic [1:0]  mode;
    logic        tft;
    logic [10:0] w;
    logic [10:0] h;
    logic [31:0] sp;
    logic [31:0] size;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd3, 2'd0, 1'b0, 11'd16,   11'd8,    32'h0,          32'h280},
    '{3'd1, 2'd0, 1'b1, 11'd32,   11'd4,    32'h0,          32'h40},
    '{3'd2, 2'd1, 1'b0, 11'd10,   11'd10,   32'h0,          32'h10},
    '{3'd4, 2'd2, 1'b1, 11'd20,   11'd5,    32'h0,          32'd200},
    '{3'd7, 2'd0, 1'b0, 11'd20,   11'd5,    32'h0,          32'd712},
    '{3'd5, 2'd0, 1'b0, 11'd20,   11'd5,    32'h0,          32'd709},
    '{3'd6, 2'd0, 1'b1, 11'd20,   11'd5,    32'h0,          32'd710},
    '{3'd0, 2'd0, 1'b0, 11'd8,    11'd8,    32'h0,          32'd0},
    '{3'd3, 2'd2, 1'b0, 11'd8,    11'd200,  32'hA064_0000,  32'h10000},
    '{3'd3, 2'd2, 1'b0, 11'd8,    11'd200,  32'h8032_0000,  32'h10000},
    '{3'd3, 2'd2, 1'b0, 11'd8,    11'd200,  32'h2064_0000,  32'h10000},
    '{3'd6, 2'd0, 1'b1, 11'd1024, 11'd1024, 32'h0,          32'h200200},
    '{3'd6, 2'd0, 1'b1, 11'd1024, 11'd1024, 32'h0,          32'h2001FD},
    '{3'd1, 2'd3, 1'b0, 11'd7,    11'd3,    32'hA3FF_0000,  32'd0}
  };

  logic clk, rst_n, hdr_valid, tft_mode;
  logic [15:0] hdr_word;
  logic [1:0]  load_mode;
  logic [DIM_W-1:0] panel_width, panel_height;
  logic [31:0] subpanel;
  logic [SIZE_W-1:0] buf_bytes;
  logic done, skip, direct16, sync_err;
  logic [4:0] bpp;
  logic [9:0] data_offset;
  logic [DIM_W:0] stride;
  logic [LINE_W-1:0] first_line;
  logic [DIM_W-1:0] line_count;

  int tests = 0, fails = 0;
  bit finished = 0;

  frame_hdr_decode #(.DIM_W(DIM_W), .LINE_W(LINE_W), .SIZE_W(SIZE_W)) dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_word(hdr_word),
    .load_mode(load_mode), .tft_mode(tft_mode), .panel_width(panel_width),
    .panel_height(panel_height), .subpanel(subpanel), .buf_bytes(buf_bytes),
    .done(done), .skip(skip), .bpp(bpp), .direct16(direct16),
    .data_offset(data_offset), .stride(stride), .first_line(first_line),
    .line_count(line_count), .sync_err(sync_err));

  initial clk = 0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic [11:0] noise);
    hdr_word     = {noise[0], v.code, noise};
    load_mode    = v.mode;
    tft_mode     = v.tft;
    panel_width  = v.w;
    panel_height = v.h;
    subpanel     = v.sp | 32'h1C00_FFFF;
    buf_bytes    = v.size;
  endtask

  task automatic check_vec(input vec_t v);
    longint eb, eo, es, ne, ef, ec;
    eb = (v.code == 0) ? 0 : (v.code == 1) ? 2 : (v.code == 2) ? 4 : (v.code == 3) ? 8 : 16;
    eo = (v.mode == 2) ? 0 : (v.code >= 3) ? 512 : 32;
    es = (longint'(v.w) * eb) / 8;
    ne = eo + (longint'(v.w) * longint'(v.h) * eb) / 8;
    ef = 0; ec = v.h;
    if (v.sp[31]) begin
      if (v.sp[29]) ef = v.sp[25:16];
      else          ec = v.sp[25:16];
    end
    chk("R1 done", done, 1);
    chk("R2 bpp", bpp, eb);
    chk("R3 skip", skip, v.code == 0);
    chk("R4 offset", data_offset, eo);
    chk("R5 direct16", direct16, (eb == 16) && v.tft);
    chk("R6 stride", stride, es);
    chk("R7 R10 sync_err", sync_err, (v.code != 0) && (ne > longint'(v.size) + 2));
    chk("R8 first_line", first_line, ef);
    chk("R8 line_count", line_count, ec);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; hdr_valid = 0;
    apply(VECS[0], 12'h000);
    repeat (3) @(negedge clk);
    // R9 reset state
    chk("R9 reset done", done, 0);
    chk("R9 reset bpp", bpp, 0);
    chk("R9 reset stride", stride, 0);
    chk("R9 reset line_count", line_count, 0);
    chk("R9 reset sync_err", sync_err, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 no strobe no done", done, 0);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i], 12'(i * 12'h5A3));
      hdr_valid = 1;
      @(negedge clk);
      hdr_valid = 0;
      check_vec(VECS[i]);
      @(negedge clk);
      chk("R1 single pulse", done, 0);
    end

    // R9 hold: change every input without a strobe
    apply(VECS[3], 12'hFFF);
    hdr_valid = 1;
    @(negedge clk);
    hdr_valid = 0;
    check_vec(VECS[3]);
    apply(VECS[7], 12'h123);
    repeat (3) @(negedge clk);
    chk("R9 hold done", done, 0);
    chk("R9 hold bpp", bpp, 16);
    chk("R9 hold stride", stride, 40);
    chk("R9 hold direct16", direct16, 1);
    chk("R9 hold skip", skip, 0);

    // R1 back-to-back strobes
    apply(VECS[0], 12'h000);
    hdr_valid = 1;
    @(negedge clk);
    check_vec(VECS[0]);
    apply(VECS[7], 12'h000);
    @(negedge clk);
    hdr_valid = 0;
    check_vec(VECS[7]);
    @(negedge clk);
    chk("R1 after burst", done, 0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule